// File: doc/BRIEF.md
# Dual General-Purpose Pin Port Controller

This block controls two 16-pin general-purpose ports, A and B, from a simple register read/write bus. Each port has a 32-bit configuration word that holds a drive-enable bit and a pull-up bit for every pin, and a 16-bit output latch. A peripheral side can also drive any pin, with its own enable and value vectors for each port. The block combines the processor drive, the peripheral drive and the pull-ups into one level per pin, shows those levels on output vectors, and returns them when a port's data word is read.

Each bus write to a configuration word or a data word compares the port's level just before the write with the level the write produces. When the two differ, the block raises a one-cycle change pulse for that port and shows both the old and the new level vector. A pin-interrupt setup word is also present. Because interrupt generation is not built, any nonzero value written to it raises an unsupported-feature pulse.

Top module: `dual_gpio_ctrl`

## Requirements
- R1: After reset all configuration words, output latches and the interrupt setup word are zero, so `pin_a` and `pin_b` read 0 and no change or unsupported pulse is raised.
- R2: In a configuration word, bit 2n enables the processor drive of pin n and bit 2n+1 enables the pull-up of pin n.
- R3: The level of pin n is (cpu_drive AND latch bit) OR (peripheral_enable AND peripheral bit) OR (pull-up AND NOT cpu_drive AND NOT peripheral_enable).
- R4: Reading a port data word returns the resolved levels in bits 15:0 with bits 31:16 zero, and not the latch contents.
- R5: A write to a port's configuration or data word raises that port's change pulse for exactly the cycle after the write, carrying the old and new levels, only when the new level differs from the level before the write.
- R6: A change on the peripheral inputs alone updates the pin levels and the read value but raises no change pulse.
- R7: Register map, with `req_size` 1 meaning a 16-bit access and 2 meaning a 32-bit access: 0x00 port A configuration (32-bit), 0x04 port A data (16-bit), 0x08 port B configuration (32-bit), 0x0C port B data (16-bit), 0x10 interrupt setup (16-bit, reads back the stored value).
- R8: An access with the wrong size or to an offset not in the map returns `rsp_err` = 1 and changes no register.
- R9: Writing a nonzero value to the interrupt setup word raises `unsup_err` for the one cycle after the write; writing zero does not.
- R10: Every request cycle gives `rsp_valid` = 1 in the next cycle, with `rsp_rdata` holding the read value as it stood when the request was taken (zero for writes and errors).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_size | input | 2 | Access size: 1 = 16-bit, 2 = 32-bit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read data |
| per_dir_a | input | 16 | Peripheral drive enable for port A |
| per_dat_a | input | 16 | Peripheral drive value for port A |
| per_dir_b | input | 16 | Peripheral drive enable for port B |
| per_dat_b | input | 16 | Peripheral drive value for port B |
| pin_a | output | 16 | Resolved levels of port A |
| pin_b | output | 16 | Resolved levels of port B |
| chg_a | output | 1 | Port A level changed by the last write |
| old_a | output | 16 | Port A level before that write |
| new_a | output | 16 | Port A level after that write |
| chg_b | output | 1 | Port B level changed by the last write |
| old_b | output | 16 | Port B level before that write |
| new_b | output | 16 | Port B level after that write |
| unsup_err | output | 1 | Nonzero write to the interrupt setup word |

## Verification
On every cycle the assertions check that a change pulse appears only after a write and always with differing old and new vectors, that the reported new level matches the live level when the peripheral side stayed still, that an erroneous access selects no register and leaves every configuration word unchanged, that each request gets a response one cycle later, and that an unsupported pulse only comes with a nonzero stored interrupt word. The bit packing of the configuration word, the exact three-way resolution across many drive and pull-up mixes, the zero upper half of data reads and the absence of a pulse for peripheral-only changes are shown only by the bench's table and directed scenarios.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int PINS   = 16;
  localparam int BUS_W  = 32;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Drive-enable bits sit at even positions of the configuration word.
  function automatic logic [PINS-1:0] cfg_drive(input logic [2*PINS-1:0] cfg);
    logic [PINS-1:0] r;
    for (int i = 0; i < PINS; i++) r[i] = cfg[2*i];
    return r;
  endfunction

  // Pull-up bits sit at odd positions of the configuration word.
  function automatic logic [PINS-1:0] cfg_pull(input logic [2*PINS-1:0] cfg);
    logic [PINS-1:0] r;
    for (int i = 0; i < PINS; i++) r[i] = cfg[2*i+1];
    return r;
  endfunction

  function automatic logic [PINS-1:0] pin_level(
    input logic [2*PINS-1:0] cfg,
    input logic [PINS-1:0]   latch,
    input logic [PINS-1:0]   pdir,
    input logic [PINS-1:0]   pdat
  );
    logic [PINS-1:0] drv;
    logic [PINS-1:0] pul;
    drv = cfg_drive(cfg);
    pul = cfg_pull(cfg);
    return (drv & latch) | (pdir & pdat) | (pul & ~(drv | pdir));
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int ADDR_W = 8,
  parameter int NPORT  = 2
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic [NPORT-1:0]  hit_cfg,
  output logic [NPORT-1:0]  hit_dat,
  output logic              hit_ictl,
  output logic              bad
);
  import gpio_pkg::*;

  localparam int STRIDE    = 8;
  localparam int ICTL_OFFS = NPORT * STRIDE;

  for (genvar p = 0; p < NPORT; p++) begin : g_port_dec
    localparam logic [ADDR_W-1:0] CFG_OFFS = ADDR_W'(p * STRIDE);
    localparam logic [ADDR_W-1:0] DAT_OFFS = ADDR_W'(p * STRIDE + 4);
    assign hit_cfg[p] = req_valid && (req_addr == CFG_OFFS) && (req_size == SZ_WORD);
    assign hit_dat[p] = req_valid && (req_addr == DAT_OFFS) && (req_size == SZ_HALF);
  end

  assign hit_ictl = req_valid && (req_addr == ADDR_W'(ICTL_OFFS)) && (req_size == SZ_HALF);
  assign bad      = req_valid && !(|hit_cfg) && !(|hit_dat) && !hit_ictl;

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int PINS  = gpio_pkg::PINS,
  parameter int BUS_W = gpio_pkg::BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_dat,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [PINS-1:0]   per_dir,
  input  logic [PINS-1:0]   per_dat,
  output logic [2*PINS-1:0] cfg_q,
  output logic [PINS-1:0]   level,
  output logic              chg,
  output logic [PINS-1:0]   old_lvl,
  output logic [PINS-1:0]   new_lvl
);
  import gpio_pkg::*;

  localparam int CW = 2 * PINS;

  logic [PINS-1:0] latch_q;
  logic [CW-1:0]   cfg_nx;
  logic [PINS-1:0] latch_nx;
  logic [PINS-1:0] level_nx;
  logic            wr_any;
  logic            chg_q;
  logic [PINS-1:0] old_q;
  logic [PINS-1:0] new_q;

  assign wr_any   = wr_cfg || wr_dat;
  assign cfg_nx   = wr_cfg ? wdata[CW-1:0] : cfg_q;
  assign latch_nx = wr_dat ? wdata[PINS-1:0] : latch_q;
  assign level    = pin_level(cfg_q, latch_q, per_dir, per_dat);
  assign level_nx = pin_level(cfg_nx, latch_nx, per_dir, per_dat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      latch_q <= '0;
      chg_q   <= 1'b0;
      old_q   <= '0;
      new_q   <= '0;
    end else begin
      cfg_q   <= cfg_nx;
      latch_q <= latch_nx;
      chg_q   <= wr_any && (level_nx != level);
      if (wr_any) begin
        old_q <= level;
        new_q <= level_nx;
      end
    end
  end

  assign chg     = chg_q;
  assign old_lvl = old_q;
  assign new_lvl = new_q;

  assert_pulse_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> !chg);

  assert_pulse_has_diff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (old_lvl != new_lvl));

  assert_new_matches_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> ((new_lvl == level) || !$stable(per_dir) || !$stable(per_dat)));

endmodule

// File: rtl/dual_gpio_ctrl.sv
module dual_gpio_ctrl #(
  parameter int ADDR_W = 8,
  parameter int PINS   = gpio_pkg::PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  input  logic [PINS-1:0]   per_dir_a,
  input  logic [PINS-1:0]   per_dat_a,
  input  logic [PINS-1:0]   per_dir_b,
  input  logic [PINS-1:0]   per_dat_b,
  output logic [PINS-1:0]   pin_a,
  output logic [PINS-1:0]   pin_b,
  output logic              chg_a,
  output logic [PINS-1:0]   old_a,
  output logic [PINS-1:0]   new_a,
  output logic              chg_b,
  output logic [PINS-1:0]   old_b,
  output logic [PINS-1:0]   new_b,
  output logic              unsup_err
);
  import gpio_pkg::*;

  localparam int NPORT  = 2;
  localparam int BW     = 32;
  localparam int CW     = 2 * PINS;
  localparam int ICTL_W = 16;

  logic [NPORT-1:0]           hit_cfg;
  logic [NPORT-1:0]           hit_dat;
  logic                       hit_ictl;
  logic                       dec_bad;
  logic [NPORT-1:0][PINS-1:0] pdir_v;
  logic [NPORT-1:0][PINS-1:0] pdat_v;
  logic [NPORT-1:0][CW-1:0]   cfg_v;
  logic [NPORT-1:0][PINS-1:0] lvl_v;
  logic [NPORT-1:0]           chg_v;
  logic [NPORT-1:0][PINS-1:0] old_v;
  logic [NPORT-1:0][PINS-1:0] new_v;
  logic [ICTL_W-1:0]          ictl_q;
  logic [BW-1:0]              rd_mux;
  logic                       ictl_wr;
  logic                       ictl_nonzero;
  logic                       rsp_valid_q;
  logic                       rsp_err_q;
  logic [BW-1:0]              rsp_rdata_q;
  logic                       unsup_q;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NPORT(NPORT)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .hit_cfg   (hit_cfg),
    .hit_dat   (hit_dat),
    .hit_ictl  (hit_ictl),
    .bad       (dec_bad)
  );

  assign pdir_v[0] = per_dir_a;
  assign pdat_v[0] = per_dat_a;
  assign pdir_v[1] = per_dir_b;
  assign pdat_v[1] = per_dat_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_port #(.PINS(PINS), .BUS_W(BW)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cfg  (hit_cfg[p] && req_write),
      .wr_dat  (hit_dat[p] && req_write),
      .wdata   (req_wdata),
      .per_dir (pdir_v[p]),
      .per_dat (pdat_v[p]),
      .cfg_q   (cfg_v[p]),
      .level   (lvl_v[p]),
      .chg     (chg_v[p]),
      .old_lvl (old_v[p]),
      .new_lvl (new_v[p])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (hit_cfg[p]) rd_mux = BW'(cfg_v[p]);
      if (hit_dat[p]) rd_mux = BW'(lvl_v[p]);
    end
    if (hit_ictl) rd_mux = BW'(ictl_q);
  end

  assign ictl_wr      = hit_ictl && req_write;
  assign ictl_nonzero = (req_wdata[ICTL_W-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ictl_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      unsup_q     <= 1'b0;
    end else begin
      if (ictl_wr) ictl_q <= req_wdata[ICTL_W-1:0];
      rsp_valid_q <= req_valid;
      rsp_err_q   <= dec_bad;
      rsp_rdata_q <= (req_valid && !req_write && !dec_bad) ? rd_mux : '0;
      unsup_q     <= ictl_wr && ictl_nonzero;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign unsup_err = unsup_q;
  assign pin_a     = lvl_v[0];
  assign pin_b     = lvl_v[1];
  assign chg_a     = chg_v[0];
  assign old_a     = old_v[0];
  assign new_a     = new_v[0];
  assign chg_b     = chg_v[1];
  assign old_b     = old_v[1];
  assign new_b     = new_v[1];

  assert_err_selects_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bad |-> (!(|hit_cfg) && !(|hit_dat) && !hit_ictl));

  assert_err_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bad |=> ($stable(cfg_v) && $stable(ictl_q) && rsp_err));

  assert_single_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_cfg, hit_dat, hit_ictl}));

  assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_unsup_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_err |-> (ictl_q != '0));

endmodule

// File: tb/sim_dual_gpio_ctrl.sv
module sim_dual_gpio_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // row: {cfg[79:48], latch[47:32], per_dir[31:16], per_dat[15:0]}
  localparam logic [79:0] VEC [NVEC] = '{
    {32'h0000_0001, 16'h0001, 16'h0000, 16'h0000},
    {32'hAAAA_AAAA, 16'h0000, 16'h0000, 16'h0000},
    {32'hAAAA_AAAA, 16'h0000, 16'h00FF, 16'h000F},
    {32'h5555_5555, 16'h1234, 16'hFF00, 16'hF000},
    {32'hFFFF_FFFF, 16'h0000, 16'h0000, 16'h0000},
    {32'h0000_0006, 16'h0000, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [15:0] per_dir_a = '0, per_dat_a = '0, per_dir_b = '0, per_dat_b = '0;
  logic [15:0] pin_a, pin_b, old_a, new_a, old_b, new_b;
  logic        chg_a, chg_b, unsup_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // captured at the sample point after a bus cycle
  logic        s_valid, s_err, s_chg_a, s_chg_b, s_unsup;
  logic [31:0] s_rdata;
  logic [15:0] s_old_a, s_new_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_gpio_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .per_dir_a(per_dir_a), .per_dat_a(per_dat_a),
    .per_dir_b(per_dir_b), .per_dat_b(per_dat_b),
    .pin_a(pin_a), .pin_b(pin_b),
    .chg_a(chg_a), .old_a(old_a), .new_a(new_a),
    .chg_b(chg_b), .old_b(old_b), .new_b(new_b),
    .unsup_err(unsup_err)
  );

  // Bench model of the resolution, pin by pin.
  function automatic logic [15:0] expect_lvl(input logic [31:0] cfg, input logic [15:0] lat,
                                             input logic [15:0] pd, input logic [15:0] pv);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      if (cfg[2*n])      r[n] = lat[n];
      else if (pd[n])    r[n] = pv[n];
      else               r[n] = cfg[2*n+1];
      if (cfg[2*n] && pd[n]) r[n] = lat[n] | pv[n];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    s_valid = rsp_valid; s_err = rsp_err; s_rdata = rsp_rdata;
    s_chg_a = chg_a; s_chg_b = chg_b; s_unsup = unsup_err;
    s_old_a = old_a; s_new_a = new_a;
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_a", {16'h0, pin_a}, 32'h0);
    chk("R1 pin_b", {16'h0, pin_b}, 32'h0);
    chk("R1 chg", {30'h0, chg_a, chg_b}, 32'h0);
    chk("R1 unsup", {31'h0, unsup_err}, 32'h0);
    bus(1'b0, 8'h00, 2'd2, 0);
    chk("R1 cfg A read", s_rdata, 32'h0);
    bus(1'b0, 8'h0C, 2'd1, 0);
    chk("R1 data B read", s_rdata, 32'h0);
    chk("R10 rsp_valid", {31'h0, s_valid}, 32'h1);

    // R2 R3 R4 table on both ports
    for (int k = 0; k < NVEC; k++) begin
      per_dir_a = VEC[k][31:16]; per_dat_a = VEC[k][15:0];
      per_dir_b = ~VEC[k][31:16]; per_dat_b = VEC[k][15:0];
      bus(1'b1, 8'h00, 2'd2, VEC[k][79:48]);
      bus(1'b1, 8'h04, 2'd1, {16'h0, VEC[k][47:32]});
      bus(1'b1, 8'h08, 2'd2, VEC[k][79:48]);
      bus(1'b1, 8'h0C, 2'd1, {16'hDEAD, VEC[k][47:32]});
      e = expect_lvl(VEC[k][79:48], VEC[k][47:32], VEC[k][31:16], VEC[k][15:0]);
      bus(1'b0, 8'h04, 2'd1, 0);
      chk("R3 R4 read A", s_rdata, {16'h0, e});
      chk("R2 pin_a", {16'h0, pin_a}, {16'h0, e});
      e = expect_lvl(VEC[k][79:48], VEC[k][47:32], ~VEC[k][31:16], VEC[k][15:0]);
      bus(1'b0, 8'h0C, 2'd1, 0);
      chk("R3 R4 read B", s_rdata, {16'h0, e});
      bus(1'b0, 8'h08, 2'd2, 0);
      chk("R7 cfg B readback", s_rdata, VEC[k][79:48]);
    end

    // R4: read differs from latch (drive off, pull-up on pin 0)
    per_dir_a = '0; per_dat_a = '0; per_dir_b = '0; per_dat_b = '0;
    bus(1'b1, 8'h00, 2'd2, 32'h0);
    bus(1'b1, 8'h04, 2'd1, 32'h0000_00F0);
    bus(1'b1, 8'h00, 2'd2, 32'h0000_0002);
    chk("R5 pulse on cfg write", {31'h0, s_chg_a}, 32'h1);
    chk("R5 old level", {16'h0, s_old_a}, 32'h0);
    chk("R5 new level", {16'h0, s_new_a}, 32'h1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'h0, chg_a}, 32'h0);
    bus(1'b0, 8'h04, 2'd1, 0);
    chk("R4 read not latch", s_rdata, 32'h1);
    // same level again: no pulse
    bus(1'b1, 8'h00, 2'd2, 32'h0000_0002);
    chk("R5 no pulse same level", {31'h0, s_chg_a}, 32'h0);
    // latch write with drive off: no change
    bus(1'b1, 8'h04, 2'd1, 32'h0000_FFFF);
    chk("R5 no pulse latch hidden", {31'h0, s_chg_a}, 32'h0);
    // latch write with drive on: change 1 -> 0xFFFF
    bus(1'b1, 8'h00, 2'd2, 32'h5555_5555);
    chk("R5 pulse drive on", {30'h0, s_chg_a, s_chg_b}, 32'h2);
    chk("R5 new all ones", {16'h0, s_new_a}, 32'hFFFF);

    // R6 peripheral-only change
    bus(1'b1, 8'h08, 2'd2, 32'hAAAA_AAAA);
    @(negedge clk);
    per_dir_b = 16'h00F0; per_dat_b = 16'h0000;
    @(negedge clk);
    chk("R6 no pulse", {31'h0, chg_b}, 32'h0);
    chk("R6 pin_b follows", {16'h0, pin_b}, 32'hFF0F);
    bus(1'b0, 8'h0C, 2'd1, 0);
    chk("R6 read follows", s_rdata, 32'hFF0F);

    // R8 errors leave state alone
    bus(1'b1, 8'h00, 2'd1, 32'h0);
    chk("R8 wrong size err", {31'h0, s_err}, 32'h1);
    bus(1'b0, 8'h00, 2'd2, 0);
    chk("R8 cfg A unchanged", s_rdata, 32'h5555_5555);
    bus(1'b1, 8'h14, 2'd1, 32'h1);
    chk("R8 unknown offset err", {31'h0, s_err}, 32'h1);
    bus(1'b0, 8'h05, 2'd1, 0);
    chk("R8 misaligned read err", {31'h0, s_err}, 32'h1);
    chk("R10 err rdata zero", s_rdata, 32'h0);
    bus(1'b1, 8'h04, 2'd2, 32'h0);
    chk("R8 data word size err", {31'h0, s_err}, 32'h1);
    chk("R8 no pulse on err", {31'h0, s_chg_a}, 32'h0);
    chk("R8 pin_a unchanged", {16'h0, pin_a}, 32'hFFFF);

    // R9 interrupt setup word
    bus(1'b1, 8'h10, 2'd1, 32'h0);
    chk("R9 zero write no flag", {31'h0, s_unsup}, 32'h0);
    bus(1'b1, 8'h10, 2'd1, 32'h0003);
    chk("R9 nonzero flag", {31'h0, s_unsup}, 32'h1);
    chk("R9 not bus error", {31'h0, s_err}, 32'h0);
    @(negedge clk);
    chk("R9 flag one cycle", {31'h0, unsup_err}, 32'h0);
    bus(1'b0, 8'h10, 2'd1, 0);
    chk("R7 ictl readback", s_rdata, 32'h3);
    bus(1'b1, 8'h10, 2'd2, 32'h5);
    chk("R8 ictl size err", {32'(s_err), 32'(s_unsup)} == 64'h1_0000_0000 ? 32'h1 : 32'h0, 32'h1);
    @(negedge clk);
    chk("R10 idle no rsp", {31'h0, rsp_valid}, 32'h0);

    // R1 reset again clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    per_dir_b = '0;
    @(negedge clk);
    chk("R1 pin_a after reset", {16'h0, pin_a}, 32'h0);
    bus(1'b0, 8'h10, 2'd1, 0);
    chk("R1 ictl after reset", s_rdata, 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule